// File: doc/BRIEF.md
# Three-Channel Fan Tachometer Period Monitor

This block measures how fast each of three fans turns by timing the gap between successive tach pulses. Each tach input is asynchronous; it is brought into the core clock domain and reduced to a one-cycle rising-edge event. Between two such events a per-channel counter advances once for every pulse on the 90 kHz reference tick. At each edge the count is latched into a 16-bit period register. Software derives fan speed from the reciprocal of that period.

A fan that stops or is missing produces no edges. The counter then climbs to all-ones and stays there. The period register is forced to 0xFFFF, which software treats as an invalid reading. The register also holds 0xFFFF from reset until the first complete period has been timed.

The host reaches the period registers through a two-port window: it writes an index to one port and reads the selected byte from the other. Each channel exposes a low byte and a high byte. Reading the low byte freezes that channel's high byte, so the following high-byte read belongs to the same 16-bit sample even if a new period lands in between.

Top module: `fan_period_mon`

## Requirements
- R1: After reset every channel's period reads 0xFFFF (low byte 0xFF, high byte 0xFF).
- R2: Each tach input passes through a two-flop synchroniser and only rising edges count. The latched period equals the number of reference ticks seen from the cycle of one detected rising edge up to, but not including, the cycle of the next.
- R3: The first rising edge after reset only starts a measurement; the period keeps reading 0xFFFF until a second edge completes one.
- R4: The counter saturates at 0xFFFF and never wraps. Once it reaches 0xFFFF the period register becomes 0xFFFF. The edge after a stall latches 0xFFFF again, and the following edge yields a valid period.
- R5: A host write to the index port, runtime offset 0x70, loads the 8-bit index. A host read at that offset returns the current index.
- R6: The data port, offset 0x71, returns the byte selected by the index. Channel c (c = 0, 1, 2) has its low byte at index 0x28 + 2c and its high byte at 0x29 + 2c.
- R7: A data-port read of a channel's low byte captures that channel's high byte. A later high-byte read returns the captured byte, not the live one.
- R8: A data-port read at an index outside 0x28 to 0x2D returns 0x00. Writes to the data port change no register.
- R9: The channels are independent: edges on one channel never change another channel's period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle enable at the 90 kHz reference rate |
| tach_in | input | 3 | Asynchronous tach pulse inputs, one per channel |
| bus_addr | input | 8 | Runtime register offset of the host access |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe (captures the high byte on a low-byte read) |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, valid in the same cycle as the address |

## Verification
The assertions check the following on every cycle:
- a saturated counter stays saturated;
- saturation forces the period to 0xFFFF;
- the period never moves without an edge or a stall;
- an index write takes effect;
- low-byte reads capture the high byte;
- out-of-window reads return zero.

Only the bench scenarios can show the rest:
- that latched values equal the tick count between real edges;
- that the first edge merely arms the measurement;
- that a fan recovering from a stall reports correctly after two edges;
- that a high-byte read after a fresh period still returns the older frozen sample.

// File: rtl/fanmon_pkg.sv
package fanmon_pkg;
    parameter int CNT_W  = 16;
    parameter int BYTE_W = 8;

    typedef logic [CNT_W-1:0]  period_t;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/tach_edge_sync.sv
module tach_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic tach_async,
    output logic rise_o
);
    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = tach_async;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.sync & ~st_q.prev;
endmodule

// File: rtl/tach_period_ch.sv
module tach_period_ch
    import fanmon_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rise,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] period_o
);
    localparam logic [CW-1:0] SAT = {CW{1'b1}};

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] period;
        logic          armed;
    } ch_st_t;

    ch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rise) begin
            if (st_q.armed) st_d.period = st_q.cnt;
            st_d.armed = 1'b1;
            st_d.cnt   = tick ? CW'(1) : '0;
        end else if (st_q.cnt == SAT) begin
            st_d.period = SAT;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt    <= '0;
            st_q.period <= SAT;
            st_q.armed  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o    = st_q.cnt;
    assign period_o = st_q.period;
endmodule

// File: rtl/tach_reg_window.sv
module tach_reg_window
    import fanmon_pkg::*;
#(
    parameter int          NCH      = 3,
    parameter logic [7:0]  IDX_PORT = 8'h70,
    parameter logic [7:0]  DAT_PORT = 8'h71,
    parameter logic [7:0]  BASE_IDX = 8'h28
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [7:0]                 bus_addr,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [7:0]                 bus_wdata,
    input  logic [NCH-1:0][CNT_W-1:0]  period_i,
    output logic [7:0]                 bus_rdata,
    output logic [7:0]                 index_o,
    output logic [NCH-1:0][BYTE_W-1:0] hold_o
);
    localparam int SPAN = 2 * NCH;

    typedef struct packed {
        logic [7:0]                 index;
        logic [NCH-1:0][BYTE_W-1:0] hold;
    } win_st_t;

    win_st_t st_d, st_q;

    logic [7:0] offs;
    logic       in_win;

    always_comb begin
        offs   = st_q.index - BASE_IDX;
        in_win = (st_q.index >= BASE_IDX) && (int'(offs) < SPAN);
    end

    always_comb begin
        st_d      = st_q;
        bus_rdata = '0;
        if (bus_wr && bus_addr == IDX_PORT) st_d.index = bus_wdata;
        if (bus_addr == IDX_PORT) begin
            bus_rdata = st_q.index;
        end else if (bus_addr == DAT_PORT && in_win) begin
            for (int c = 0; c < NCH; c++) begin
                if (offs[7:1] == 7'(c)) begin
                    if (offs[0]) begin
                        bus_rdata = st_q.hold[c];
                    end else begin
                        bus_rdata = period_i[c][BYTE_W-1:0];
                        if (bus_rd) st_d.hold[c] = period_i[c][CNT_W-1:BYTE_W];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.index <= '0;
            st_q.hold  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign index_o = st_q.index;
    assign hold_o  = st_q.hold;
endmodule

// File: rtl/fan_period_mon.sv
module fan_period_mon
    import fanmon_pkg::*;
#(
    parameter int         NCH      = 3,
    parameter logic [7:0] IDX_PORT = 8'h70,
    parameter logic [7:0] DAT_PORT = 8'h71,
    parameter logic [7:0] BASE_IDX = 8'h28
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ref_tick,
    input  logic [NCH-1:0] tach_in,
    input  logic [7:0]     bus_addr,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [7:0]     bus_wdata,
    output logic [7:0]     bus_rdata
);
    logic [NCH-1:0]                 rise_w;
    logic [NCH-1:0][CNT_W-1:0]      cnt_w;
    logic [NCH-1:0][CNT_W-1:0]      period_w;
    logic [NCH-1:0][BYTE_W-1:0]     hold_w;
    logic [7:0]                     index_w;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        tach_edge_sync u_sync (
            .clk        (clk),
            .rst_n      (rst_n),
            .tach_async (tach_in[c]),
            .rise_o     (rise_w[c])
        );
        tach_period_ch #(.CW(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (ref_tick),
            .rise     (rise_w[c]),
            .cnt_o    (cnt_w[c]),
            .period_o (period_w[c])
        );
    end

    tach_reg_window #(
        .NCH(NCH), .IDX_PORT(IDX_PORT), .DAT_PORT(DAT_PORT), .BASE_IDX(BASE_IDX)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .period_i  (period_w),
        .bus_rdata (bus_rdata),
        .index_o   (index_w),
        .hold_o    (hold_w)
    );
endmodule

// File: rtl/fan_period_mon_chk.sv
module fan_period_mon_chk
    import fanmon_pkg::*;
#(
    parameter int         NCH      = 3,
    parameter logic [7:0] IDX_PORT = 8'h70,
    parameter logic [7:0] DAT_PORT = 8'h71,
    parameter logic [7:0] BASE_IDX = 8'h28
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [7:0]                 bus_addr,
    input logic                       bus_wr,
    input logic                       bus_rd,
    input logic [7:0]                 bus_wdata,
    input logic [7:0]                 bus_rdata,
    input logic [NCH-1:0]             rise_w,
    input logic [NCH-1:0][CNT_W-1:0]  cnt_w,
    input logic [NCH-1:0][CNT_W-1:0]  period_w,
    input logic [NCH-1:0][BYTE_W-1:0] hold_w,
    input logic [7:0]                 index_w
);
    localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        // R4
        sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_w[c] == SAT && !rise_w[c]) |=> cnt_w[c] == SAT);
        // R4
        sat_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_w[c] == SAT) |=> period_w[c] == SAT);
        // R2
        period_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!rise_w[c] && cnt_w[c] != SAT) |=> $stable(period_w[c]));
        // R7
        hold_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && bus_addr == DAT_PORT && index_w == 8'(int'(BASE_IDX) + 2*c))
            |=> hold_w[c] == $past(period_w[c][CNT_W-1:BYTE_W]));
    end

    // R5
    index_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == IDX_PORT) |=> index_w == $past(bus_wdata));

    // R8
    out_window_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == DAT_PORT &&
         (int'(index_w) < int'(BASE_IDX) || int'(index_w) >= int'(BASE_IDX) + 2*NCH))
        |-> bus_rdata == 8'h00);
endmodule

bind fan_period_mon fan_period_mon_chk #(
    .NCH(NCH), .IDX_PORT(IDX_PORT), .DAT_PORT(DAT_PORT), .BASE_IDX(BASE_IDX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .rise_w    (rise_w),
    .cnt_w     (cnt_w),
    .period_w  (period_w),
    .hold_w    (hold_w),
    .index_w   (index_w)
);

// File: tb/fan_period_mon_tb.sv
module fan_period_mon_tb;
    localparam int CLK_NS = 10;
    localparam int NCH    = 3;
    localparam logic [7:0] IDXP = 8'h70;
    localparam logic [7:0] DATP = 8'h71;
    localparam logic [7:0] BASE = 8'h28;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           ref_tick = 1'b0;
    logic [NCH-1:0] tach_in = '0;
    logic [7:0]     bus_addr = '0;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [7:0]     bus_wdata = '0;
    logic [7:0]     bus_rdata;

    int checks = 0;
    int errors = 0;
    int tick_div = 1;
    int cyc = 0;
    bit done = 1'b0;

    fan_period_mon #(.NCH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .tach_in(tach_in),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #(CLK_NS/2) clk = ~clk;

    always @(negedge clk) begin
        cyc      = cyc + 1;
        ref_tick = ((cyc % tick_div) == 0);
    end

    function automatic int exp_period(int spacing, int div);
        return spacing / div;
    endfunction

    function automatic logic [7:0] idx_lo(int ch);
        return 8'(int'(BASE) + 2*ch);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_index(logic [7:0] idx);
        @(negedge clk);
        bus_addr = IDXP; bus_wdata = idx; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_byte(logic [7:0] idx, output logic [7:0] val);
        set_index(idx);
        bus_addr = DATP; bus_rd = 1'b1;
        #(CLK_NS/4);
        val = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd16(int ch, output int val);
        logic [7:0] lo, hi;
        rd_byte(idx_lo(ch), lo);
        rd_byte(idx_lo(ch) + 8'd1, hi);
        val = {16'd0, hi, lo};
    endtask

    task automatic one_edge(int ch);
        @(negedge clk);
        tach_in[ch] = 1'b1;
        repeat (3) @(negedge clk);
        tach_in[ch] = 1'b0;
    endtask

    // two rising edges exactly s cycles apart, then settle
    task automatic two_edges(int ch, int s);
        @(negedge clk);
        tach_in[ch] = 1'b1;
        repeat (3) @(negedge clk);
        tach_in[ch] = 1'b0;
        repeat (s - 3) @(negedge clk);
        tach_in[ch] = 1'b1;
        repeat (3) @(negedge clk);
        tach_in[ch] = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        logic [7:0] b;
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        for (int c = 0; c < NCH; c++) begin
            rd16(c, v);
            chk("R1 reset period", v, 16'hFFFF);
        end

        // R3 single edge only arms
        tick_div = 1;
        one_edge(1);
        repeat (8) @(negedge clk);
        rd16(1, v);
        chk("R3 armed only", v, 16'hFFFF);
        // R2 following pair
        two_edges(1, 50);
        rd16(1, v);
        chk("R2 ch1 spacing 50", v, exp_period(50, 1));

        // R2 tick divider
        tick_div = 3;
        two_edges(0, 300);
        rd16(0, v);
        chk("R2 ch0 div3", v, exp_period(300, 3));

        // R9 independence
        tick_div = 1;
        two_edges(0, 300);
        two_edges(1, 77);
        rd16(0, v);
        chk("R9 ch0 untouched", v, 300);
        rd16(1, v);
        chk("R9 ch1 value", v, 77);

        // R7 frozen high byte
        rd_byte(idx_lo(0), b);
        chk("R7 low byte", int'(b), 8'h2C);
        two_edges(0, 700);
        rd_byte(idx_lo(0) + 8'd1, b);
        chk("R7 frozen high", int'(b), 8'h01);
        rd16(0, v);
        chk("R7 fresh pair", v, 700);

        // R5 index readback
        set_index(8'hA5);
        bus_addr = IDXP;
        #(CLK_NS/4);
        chk("R5 index readback", int'(bus_rdata), 8'hA5);

        // R8 out-of-window and write-ignore
        rd_byte(BASE - 8'd1, b);
        chk("R8 below window", int'(b), 0);
        rd_byte(BASE + 8'(2*NCH), b);
        chk("R8 above window", int'(b), 0);
        set_index(idx_lo(1));
        bus_addr = DATP; bus_wdata = 8'h00; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd16(1, v);
        chk("R8 data write ignored", v, 77);

        // R6 channel 2 mapping
        two_edges(2, 40);
        rd16(2, v);
        chk("R6 ch2 mapping", v, 40);

        // R4 stall and recovery
        repeat (65600) @(negedge clk);
        rd16(2, v);
        chk("R4 stall saturates", v, 16'hFFFF);
        two_edges(2, 123);
        rd16(2, v);
        chk("R4 recovery", v, 123);

        // random patterns
        for (int i = 0; i < 30; i++) begin
            int ch, dv, n;
            ch = int'($urandom % NCH);
            dv = 1 + int'($urandom % 4);
            n  = 8 + int'($urandom % 300);
            tick_div = dv;
            two_edges(ch, n * dv);
            rd16(ch, v);
            chk("R2 random", v, exp_period(n * dv, dv));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule